// File: doc/BRIEF.md
# Buffered PWM and Frequency Modulation Channel

This block is one timer channel that drives a pulse-width-modulated pin whose period and duty can both be retuned by software while the waveform runs, with no glitch. The input clock is divided by a shared stage and then by a channel stage. Each stage has its own enable and its own divide value, and each produces a one-cycle tick rather than a derived clock. Each channel tick advances a 16-bit counter. The counter runs from 1 up to the period value and then restarts at 1.

Software writes the duty value and the period value into holding registers. The channel copies both into its working comparators only when the counter restarts, so a half-finished period is never disturbed. Two force strobes set the output as a real comparator match would. A separate general-purpose mode makes the counter loadable, which gives software a clean way to restart the channel.

Top module: `pwmfm_channel`

## Requirements
- R1: After reset the counter reads 1 and the internal level is inactive, so `pwm_out` equals `~polarity`.
- R2: With N = (glb_div+1)·(ch_div+1) clock cycles per tick, each period lasts period·N cycles and its active part lasts duty·N cycles, for any duty below the period.
- R3: The shortest legal waveform has duty 1 and period 2. With both dividers at 0 it toggles every clock cycle.
- R4: A working duty of 0 holds the output at its inactive level for the whole period.
- R5: A working duty greater than or equal to the working period holds the output at its active level.
- R6: Duty and period values written while the channel runs take effect only at the next counter restart. The period in progress keeps its old values.
- R7: `polarity`=1 makes the active level 1. `polarity`=0 makes the active level 0.
- R8: While `ch_en`=0 or `glb_en`=0, both the counter and `pwm_out` hold their values.
- R9: A `force_a` pulse sets the inactive level in the next cycle. A `force_b` pulse sets the active level in the next cycle. `force_a` wins when both are high. Neither strobe changes the counter.
- R10: When `gp_mode`=0, `cnt_wr` is ignored. When `gp_mode`=1, `cnt_wr` loads `cnt_wdata` into the counter in the next cycle. The same write sets the level to active if the held duty is nonzero and to inactive if it is zero. While `gp_mode`=1, the working comparators follow the held values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| glb_en | input | 1 | Shared prescaler enable |
| glb_div | input | 8 | Shared divide value minus one |
| ch_en | input | 1 | Channel prescaler enable |
| ch_div | input | 2 | Channel divide value minus one |
| polarity | input | 1 | 1: active level is high |
| gp_mode | input | 1 | General-purpose mode, counter loadable |
| duty_wr | input | 1 | Write strobe for the held duty value |
| duty_wdata | input | 16 | Duty value |
| per_wr | input | 1 | Write strobe for the held period value |
| per_wdata | input | 16 | Period value (2 to 0xFFFF) |
| cnt_wr | input | 1 | Counter load strobe (general-purpose mode only) |
| cnt_wdata | input | 16 | Counter load value |
| force_a | input | 1 | Force the level a duty match gives |
| force_b | input | 1 | Force the level a period match gives |
| pwm_out | output | 1 | Waveform output |
| cnt_out | output | 16 | Current counter value |

## Verification
Every level change is registered. `pwm_out` and `cnt_out` therefore move one clock after the edge that saw a tick, a force strobe or a counter load, and the bench samples them at the following falling edge. Waveform timing is checked through run lengths measured in falling-edge samples: the monitor throws away the first partial run and then compares each complete run with the queued duty·N or (period−duty)·N. For a mid-period update, the run in progress is expected to keep the old values, and the new values are expected only after the next restart.

// File: rtl/pwmfm_pkg.sv
package pwmfm_pkg;
  localparam int CNT_W_DEF  = 16;
  localparam int GDIV_W_DEF = 8;
  localparam int CDIV_W_DEF = 2;

  typedef enum logic {
    LVL_IDLE   = 1'b0,
    LVL_ACTIVE = 1'b1
  } lvl_e;
endpackage

// File: rtl/pwmfm_divider.sv
module pwmfm_divider #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic         in_tick_i,
  input  logic [W-1:0] div_i,
  output logic         tick_o
);
  logic [W-1:0] cnt_q;

  assign tick_o = en_i && in_tick_i && (cnt_q >= div_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt_q <= '0;
    else if (en_i && in_tick_i)  cnt_q <= tick_o ? '0 : cnt_q + 1'b1;
  end

  // R2: after a tick the divider restarts, so a nonzero divide never ticks twice in a row
  p_tick_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && div_i != '0) |=> (!tick_o || div_i == '0));

  // R8: a disabled stage never ticks
  p_no_tick_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |-> !tick_o);
endmodule

// File: rtl/pwmfm_compare.sv
module pwmfm_compare #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             gp_mode_i,
  input  logic             duty_wr_i,
  input  logic [CNT_W-1:0] duty_wdata_i,
  input  logic             per_wr_i,
  input  logic [CNT_W-1:0] per_wdata_i,
  input  logic             cnt_wr_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  output logic             evt_valid_o,
  output logic             evt_lvl_o,
  output logic [CNT_W-1:0] cnt_o
);
  import pwmfm_pkg::*;

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] buf_a_q, buf_b_q, act_a_q, act_b_q, cnt_q;
  logic run_tick, wrap, duty_hit, gp_load;

  assign run_tick = tick_i && !gp_mode_i;
  assign wrap     = run_tick && (cnt_q >= act_b_q);
  assign duty_hit = run_tick && !wrap && (cnt_q == act_a_q);
  assign gp_load  = gp_mode_i && cnt_wr_i;

  // held registers written by software at any time
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_a_q <= '0;
      buf_b_q <= '0;
    end else begin
      if (duty_wr_i) buf_a_q <= duty_wdata_i;
      if (per_wr_i)  buf_b_q <= per_wdata_i;
    end
  end

  // working comparators and counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_a_q <= '0;
      act_b_q <= '0;
      cnt_q   <= CNT_ONE;
    end else if (gp_mode_i) begin
      act_a_q <= buf_a_q;
      act_b_q <= buf_b_q;
      if (cnt_wr_i) cnt_q <= cnt_wdata_i;
    end else if (wrap) begin
      act_a_q <= buf_a_q;
      act_b_q <= buf_b_q;
      cnt_q   <= CNT_ONE;
    end else if (run_tick) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    evt_valid_o = gp_load || wrap || duty_hit;
    if (gp_load || wrap) evt_lvl_o = (buf_a_q != '0) ? LVL_ACTIVE : LVL_IDLE;
    else                 evt_lvl_o = LVL_IDLE;
  end

  assign cnt_o = cnt_q;

  // R2: a running tick never leaves the counter at zero
  p_cnt_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run_tick |=> (cnt_q != '0));

  // R6: a restart lands on 1 with the held values in the comparators
  p_restart_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt_q == CNT_ONE && act_a_q == $past(buf_a_q) && act_b_q == $past(buf_b_q)));

  // R6: between restarts the comparators do not move in run mode
  p_act_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!gp_mode_i && !wrap) |=> ($stable(act_a_q) && $stable(act_b_q)));

  // R8: without a tick or a load the counter holds
  p_cnt_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_tick && !gp_load) |=> $stable(cnt_q));

  // R10: a load in general-purpose mode takes the written value
  p_gp_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    gp_load |=> (cnt_q == $past(cnt_wdata_i)));
endmodule

// File: rtl/pwmfm_outstage.sv
module pwmfm_outstage (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_valid_i,
  input  logic evt_lvl_i,
  input  logic force_a_i,
  input  logic force_b_i,
  input  logic polarity_i,
  output logic pwm_o
);
  import pwmfm_pkg::*;

  lvl_e lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           lvl_q <= LVL_IDLE;
    else if (force_a_i)   lvl_q <= LVL_IDLE;
    else if (force_b_i)   lvl_q <= LVL_ACTIVE;
    else if (evt_valid_i) lvl_q <= lvl_e'(evt_lvl_i);
  end

  assign pwm_o = polarity_i ? lvl_q : !lvl_q;

  // R9: a duty-side force always leaves the inactive level
  p_force_a_r9: assert property (@(posedge clk) disable iff (!rst_n)
    force_a_i |=> (lvl_q == LVL_IDLE));

  // R9: a period-side force alone leaves the active level
  p_force_b_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (force_b_i && !force_a_i) |=> (lvl_q == LVL_ACTIVE));

  // R8: with no event and no force the level holds
  p_lvl_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt_valid_i && !force_a_i && !force_b_i) |=> $stable(lvl_q));
endmodule

// File: rtl/pwmfm_channel.sv
module pwmfm_channel
  import pwmfm_pkg::*;
#(
  parameter int CNT_W  = CNT_W_DEF,
  parameter int GDIV_W = GDIV_W_DEF,
  parameter int CDIV_W = CDIV_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              glb_en,
  input  logic [GDIV_W-1:0] glb_div,
  input  logic              ch_en,
  input  logic [CDIV_W-1:0] ch_div,
  input  logic              polarity,
  input  logic              gp_mode,
  input  logic              duty_wr,
  input  logic [CNT_W-1:0]  duty_wdata,
  input  logic              per_wr,
  input  logic [CNT_W-1:0]  per_wdata,
  input  logic              cnt_wr,
  input  logic [CNT_W-1:0]  cnt_wdata,
  input  logic              force_a,
  input  logic              force_b,
  output logic              pwm_out,
  output logic [CNT_W-1:0]  cnt_out
);
  logic glb_tick, ch_tick, evt_valid, evt_lvl;

  pwmfm_divider #(.W(GDIV_W)) u_glb_div (
    .clk(clk), .rst_n(rst_n), .en_i(glb_en), .in_tick_i(1'b1),
    .div_i(glb_div), .tick_o(glb_tick)
  );

  pwmfm_divider #(.W(CDIV_W)) u_ch_div (
    .clk(clk), .rst_n(rst_n), .en_i(ch_en), .in_tick_i(glb_tick),
    .div_i(ch_div), .tick_o(ch_tick)
  );

  pwmfm_compare #(.CNT_W(CNT_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .tick_i(ch_tick), .gp_mode_i(gp_mode),
    .duty_wr_i(duty_wr), .duty_wdata_i(duty_wdata),
    .per_wr_i(per_wr), .per_wdata_i(per_wdata),
    .cnt_wr_i(cnt_wr), .cnt_wdata_i(cnt_wdata),
    .evt_valid_o(evt_valid), .evt_lvl_o(evt_lvl), .cnt_o(cnt_out)
  );

  pwmfm_outstage u_out (
    .clk(clk), .rst_n(rst_n), .evt_valid_i(evt_valid), .evt_lvl_i(evt_lvl),
    .force_a_i(force_a), .force_b_i(force_b), .polarity_i(polarity),
    .pwm_o(pwm_out)
  );

  // R8: a channel tick requires both enables and a shared tick
  p_tick_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ch_tick |-> (glb_tick && ch_en && glb_en));
endmodule

// File: tb/pwmfm_channel_tb.sv
`timescale 1ns/1ps
module pwmfm_channel_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic glb_en = 1'b0, ch_en = 1'b0, polarity = 1'b1, gp_mode = 1'b0;
  logic [7:0] glb_div = '0;
  logic [1:0] ch_div = '0;
  logic duty_wr = 1'b0, per_wr = 1'b0, cnt_wr = 1'b0;
  logic [15:0] duty_wdata = '0, per_wdata = '0, cnt_wdata = '0;
  logic force_a = 1'b0, force_b = 1'b0;
  logic pwm_out;
  logic [15:0] cnt_out;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pwmfm_channel u_dut (
    .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .glb_div(glb_div),
    .ch_en(ch_en), .ch_div(ch_div), .polarity(polarity), .gp_mode(gp_mode),
    .duty_wr(duty_wr), .duty_wdata(duty_wdata), .per_wr(per_wr),
    .per_wdata(per_wdata), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
    .force_a(force_a), .force_b(force_b), .pwm_out(pwm_out), .cnt_out(cnt_out)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // scoreboard of expected runs
  logic  exp_lvl_q[$];
  int    exp_len_q[$];
  string exp_tag_q[$];
  bit mon_on = 1'b0;
  bit have_prev = 1'b0, synced = 1'b0;
  logic prev;
  int run;

  task automatic push(input logic lvl, input int len, input string tag);
    exp_lvl_q.push_back(lvl);
    exp_len_q.push_back(len);
    exp_tag_q.push_back(tag);
  endtask

  task automatic score(input logic lvl, input int len);
    if (exp_len_q.size() == 0) return;
    if (!synced && lvl != exp_lvl_q[0]) return;
    synced = 1'b1;
    check(lvl == exp_lvl_q[0], {exp_tag_q[0], " level"}, int'(lvl), int'(exp_lvl_q[0]));
    check(len == exp_len_q[0], {exp_tag_q[0], " run length"}, len, exp_len_q[0]);
    void'(exp_lvl_q.pop_front());
    void'(exp_len_q.pop_front());
    void'(exp_tag_q.pop_front());
  endtask

  always @(negedge clk) begin
    if (!mon_on) begin
      have_prev = 1'b0;
      synced = 1'b0;
      run = -1;
    end else if (!have_prev) begin
      prev = pwm_out;
      have_prev = 1'b1;
      run = -1;
    end else if (pwm_out == prev) begin
      if (run >= 0) run++;
    end else begin
      if (run >= 0) score(prev, run);
      prev = pwm_out;
      run = 1;
    end
  end

  task automatic drain();
    while (exp_len_q.size() != 0) @(negedge clk);
    mon_on = 1'b0;
    @(negedge clk);
  endtask

  task automatic cfg(input int g, input int c, input int a, input int b, input logic pol);
    @(negedge clk);
    ch_en = 1'b0; gp_mode = 1'b1; polarity = pol; glb_div = 8'(g); ch_div = 2'(c);
    duty_wr = 1'b1; duty_wdata = 16'(a); per_wr = 1'b1; per_wdata = 16'(b);
    @(negedge clk);
    duty_wr = 1'b0; per_wr = 1'b0; cnt_wr = 1'b1; cnt_wdata = 16'd1;
    @(negedge clk);
    cnt_wr = 1'b0; gp_mode = 1'b0; glb_en = 1'b1; ch_en = 1'b1;
  endtask

  task automatic run_wave(input int g, input int c, input int a, input int b,
                          input logic pol, input string tag);
    int n;
    n = (g + 1) * (c + 1);
    cfg(g, c, a, b, pol);
    mon_on = 1'b1;
    for (int k = 0; k < 2; k++) begin
      push(pol, a * n, tag);
      push(!pol, (b - a) * n, tag);
    end
    drain();
  endtask

  task automatic flat(input int a, input int b, input logic lvl, input string tag);
    int bad;
    bad = 0;
    cfg(0, 0, a, b, 1'b1);
    repeat (2) @(negedge clk);
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (pwm_out !== lvl) bad++;
    end
    check(bad == 0, tag, bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic p0;
    logic [15:0] c0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(pwm_out == 1'b0, "R1 reset pwm_out", int'(pwm_out), 0);
    check(cnt_out == 16'd1, "R1 reset counter", int'(cnt_out), 1);

    // R3 minimum waveform, R2 timing with several dividers, R7 polarity
    run_wave(0, 0, 1, 2, 1'b1, "R3 min wave");
    run_wave(2, 1, 3, 8, 1'b1, "R2 g2 c1");
    run_wave(4, 3, 5, 7, 1'b0, "R7 low-active R2 g4 c3");

    // R4 zero duty, R5 full duty
    flat(0, 5, 1'b0, "R4 zero duty");
    flat(5, 5, 1'b1, "R5 duty equals period");
    flat(9, 5, 1'b1, "R5 duty above period");

    // R6 mid-period update of duty and period
    cfg(1, 0, 3, 8, 1'b1);
    mon_on = 1'b1;
    @(posedge pwm_out);
    push(1'b1, 6, "R6 old duty kept");
    push(1'b0, 10, "R6 old period kept");
    push(1'b1, 12, "R6 new duty");
    push(1'b0, 8, "R6 new period");
    @(negedge clk); @(negedge clk);
    duty_wr = 1'b1; duty_wdata = 16'd6; per_wr = 1'b1; per_wdata = 16'd10;
    @(negedge clk);
    duty_wr = 1'b0; per_wr = 1'b0;
    drain();

    // R8 stop and hold through either enable
    cfg(2, 1, 3, 8, 1'b1);
    repeat (37) @(negedge clk);
    ch_en = 1'b0;
    @(negedge clk);
    p0 = pwm_out; c0 = cnt_out;
    repeat (40) @(negedge clk);
    check(pwm_out == p0 && cnt_out == c0, "R8 channel enable off holds",
          int'(cnt_out), int'(c0));
    ch_en = 1'b1;
    repeat (11) @(negedge clk);
    glb_en = 1'b0;
    @(negedge clk);
    p0 = pwm_out; c0 = cnt_out;
    repeat (40) @(negedge clk);
    check(pwm_out == p0 && cnt_out == c0, "R8 shared enable off holds",
          int'(cnt_out), int'(c0));
    glb_en = 1'b1;
    repeat (30) @(negedge clk);
    check(cnt_out != c0, "R8 counter resumes", int'(cnt_out), -1);

    // R9 force strobes while stopped
    ch_en = 1'b0;
    @(negedge clk);
    c0 = cnt_out;
    force_b = 1'b1; @(negedge clk); force_b = 1'b0;
    check(pwm_out == 1'b1, "R9 force_b active", int'(pwm_out), 1);
    force_a = 1'b1; @(negedge clk); force_a = 1'b0;
    check(pwm_out == 1'b0, "R9 force_a inactive", int'(pwm_out), 0);
    force_b = 1'b1; @(negedge clk);
    force_a = 1'b1; @(negedge clk); force_a = 1'b0; force_b = 1'b0;
    check(pwm_out == 1'b0, "R9 force_a wins", int'(pwm_out), 0);
    check(cnt_out == c0, "R9 counter untouched", int'(cnt_out), int'(c0));

    // R10 counter load rules
    cnt_wr = 1'b1; cnt_wdata = 16'd77; @(negedge clk); cnt_wr = 1'b0;
    check(cnt_out == c0, "R10 load ignored in run mode", int'(cnt_out), int'(c0));
    gp_mode = 1'b1;
    cnt_wr = 1'b1; cnt_wdata = 16'd77; @(negedge clk); cnt_wr = 1'b0;
    check(cnt_out == 16'd77, "R10 load in gp mode", int'(cnt_out), 77);
    check(pwm_out == 1'b1, "R10 load sets active for nonzero duty", int'(pwm_out), 1);
    gp_mode = 1'b0;

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule